// File: doc/BRIEF.md
# Datagram Session Receive Engine

This block sits behind a UDP receiver and interprets a small reliable-datagram protocol used to drive test and debug links inside a chip. Each datagram payload begins with a four-byte header carrying a link identifier, a command type and a 16-bit sequence number. The engine tracks one host session, identified by source IP address and UDP port. It passes the 32-bit words of data packets to the addressed link and raises acknowledgement requests for the transmit side. It also pulses clear strobes for the address-resolution table, the packet buffers and the traffic counters when a session opens or closes.

Payload bytes enter one per cycle, with start and end markers, while the source address and port are held stable for the whole packet. Data words leave as soon as they are assembled. They are speculative until a commit or abort pulse at the end of the packet says whether the packet was accepted. When an acknowledgement packet arrives from the host, the engine compares its number with the number of the last packet the transmit side sent, which is supplied on `txLastNum`, and reports the result.

Top module: `dgram_rx_engine`

## Requirements
- R1: After reset, and after any later reset, no session is held, and every pulse output (`wordValid`, `ackReq`, `dataCommit`, `dataAbort`, `ackSeen`, the three clear strobes) is low.
- R2: Header layout is byte 0 link ID, byte 1 type, bytes 2 and 3 sequence number with the high byte first. Data words are formed from four payload bytes with the first byte in bits 31:24, and each word is tagged on `wordLink` with the packet's link ID.
- R3: A type 0x03 (open) packet from any origin while no session is held locks the engine to that IP address and port. It pulses `clrArp`, `clrBuf` and `clrCnt` together and requests an acknowledgement with number 0 and the packet's link ID.
- R4: While a session is held, a packet whose source IP or port differs from the stored host is dropped. It produces no word, no acknowledgement request and no clear pulse.
- R5: A type 0x01 (data) packet from the host whose number equals the expected number, and whose length is valid, is acknowledged with its own number and pulses `dataCommit`. The expected number then increments. The expected number starts at 0 when a session opens. A data packet with no payload is valid.
- R6: A data packet whose number differs from the expected number emits no words and is not acknowledged, and the expected number is unchanged.
- R7: A data packet with the expected number whose payload length is not a multiple of 4 bytes, or exceeds MAX_WORDS words, pulses `dataAbort` instead of `dataCommit`. It is not acknowledged and the expected number is unchanged. At most MAX_WORDS words are emitted for it.
- R8: A type 0x02 (acknowledge) packet from the host never raises `ackReq`. It pulses `ackSeen`, with `ackMatch` high exactly when its number equals `txLastNum`.
- R9: A type 0x04 (close) packet from the host releases the session and pulses the three clear strobes. It requests an acknowledgement carrying its own number. Data packets that follow are dropped.
- R10: Packets of any other type, and data packets while no session is held, are dropped with no acknowledgement.
- R11: A packet shorter than four bytes has no effect.
- R12: A word appears on the outputs in the cycle after its last byte is accepted. The end-of-packet actions (acknowledgement, commit, abort, clears, lock change) appear in the cycle after the packet's last byte.
- R13: An open packet from the current host reopens the session. It clears again, acknowledges with number 0 and resets the expected number to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Payload byte valid |
| inStart | input | 1 | First byte of a datagram payload |
| inEnd | input | 1 | Last byte of a datagram payload |
| inByte | input | 8 | Payload byte |
| srcIp | input | IP_W | Source IP address of the current datagram |
| srcPort | input | PORT_W | Source UDP port of the current datagram |
| txLastNum | input | 16 | Number of the last packet sent by the transmit side |
| wordValid | output | 1 | Data word strobe |
| wordData | output | 32 | Data word |
| wordLink | output | 8 | Link ID addressed by the word |
| dataCommit | output | 1 | Words of the current data packet are accepted |
| dataAbort | output | 1 | Words of the current data packet are to be discarded |
| ackReq | output | 1 | Request to send an acknowledgement |
| ackNum | output | 16 | Number for the requested acknowledgement |
| ackLink | output | 8 | Link ID for the requested acknowledgement |
| ackSeen | output | 1 | An acknowledgement from the host was received |
| ackMatch | output | 1 | Last received acknowledgement matched `txLastNum` |
| clrArp | output | 1 | Clear the address-resolution table |
| clrBuf | output | 1 | Clear the packet buffers |
| clrCnt | output | 1 | Clear the packet counters |
| sessionLocked | output | 1 | A host session is held |

## Verification
The hardest state to reach is a data packet that passes every session and sequence test and then runs past the word cap. The engine must stop emitting at exactly MAX_WORDS words, abort rather than acknowledge, and leave the expected number where it was. The bench first opens a session, then sends a 1448-byte packet, which is one word over the cap. It checks the word count and the abort pulse, and then checks that a following in-order packet with the same number is still accepted. A length that ends mid-word is covered the same way, by a packet with one trailing byte after two full words.

// File: rtl/dgram_rx_pkg.sv
package dgram_rx_pkg;

  localparam int HDR_BYTES  = 4;
  localparam int WORD_BYTES = 4;
  localparam int SEQ_W      = 16;
  localparam int LINK_W     = 8;
  localparam int WORD_W     = 8 * WORD_BYTES;

  localparam logic [7:0] TYPE_DATA  = 8'h01;
  localparam logic [7:0] TYPE_ACK   = 8'h02;
  localparam logic [7:0] TYPE_OPEN  = 8'h03;
  localparam logic [7:0] TYPE_CLOSE = 8'h04;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic capLink;
    logic capType;
    logic capNumHi;
    logic capNumLo;
    logic capOrigin;
    logic pushByte;
    logic emitWord;
    logic doLock;
    logic doRelease;
    logic incSeq;
    logic raiseAck;
    logic commit;
    logic abort;
    logic clearAll;
    logic ackSeen;
    logic ackHit;
  } ctl_strobe_t;

endpackage

// File: rtl/dgram_rx_control.sv
module dgram_rx_control
  import dgram_rx_pkg::*;
#(
  parameter int MAX_WORDS = 360
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inEnd,
  input  logic [7:0]        inByte,
  input  logic [SEQ_W-1:0]  txLastNum,
  input  logic [7:0]        pktType,
  input  logic [7:0]        numHi,
  input  logic [SEQ_W-1:0]  pktNum,
  input  logic [SEQ_W-1:0]  expSeq,
  input  logic              locked,
  input  logic              originMatch,
  output ctl_strobe_t       strb,
  output logic [SEQ_W-1:0]  ackValue
);

  // Index of the last byte a full-size data packet may have
  localparam int LAST_IDX = HDR_BYTES - 1 + WORD_BYTES * MAX_WORDS;
  localparam int CNT_W    = $clog2(LAST_IDX + 2);
  localparam logic [CNT_W-1:0] CNT_TOP   = '1;
  localparam logic [CNT_W-1:0] IDX_LINK  = CNT_W'(0);
  localparam logic [CNT_W-1:0] IDX_TYPE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX_NHI   = CNT_W'(2);
  localparam logic [CNT_W-1:0] IDX_NLO   = CNT_W'(3);
  localparam logic [CNT_W-1:0] IDX_BODY  = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] IDX_W0END = CNT_W'(HDR_BYTES + WORD_BYTES - 1);
  localparam logic [CNT_W-1:0] IDX_LAST  = CNT_W'(LAST_IDX);

  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] idx;
  logic             inPkt;
  logic             accept;
  logic             sameHost;
  logic             fwdOk;
  logic             hdrOk;
  logic             lenOk;
  logic             seqHit;
  logic [SEQ_W-1:0] effNum;

  always_comb begin
    idx      = inStart ? '0 : byteCnt;
    accept   = inValid && (inStart || inPkt);
    sameHost = locked && originMatch;
    fwdOk    = sameHost && (pktType == TYPE_DATA) && (pktNum == expSeq);
    effNum   = (idx == IDX_NLO) ? {numHi, inByte} : pktNum;
    hdrOk    = (idx >= IDX_NLO);
    lenOk    = (idx[1:0] == 2'b11) && (idx <= IDX_LAST);
    seqHit   = (effNum == expSeq);
  end

  always_comb begin
    strb     = '0;
    ackValue = effNum;
    if (accept) begin
      strb.capLink   = (idx == IDX_LINK);
      strb.capOrigin = (idx == IDX_LINK);
      strb.capType   = (idx == IDX_TYPE);
      strb.capNumHi  = (idx == IDX_NHI);
      strb.capNumLo  = (idx == IDX_NLO);
      strb.pushByte  = (idx >= IDX_BODY);
      strb.emitWord  = fwdOk && (idx >= IDX_W0END) && (idx[1:0] == 2'b11) &&
                       (idx <= IDX_LAST);
      if (inEnd && hdrOk) begin
        unique case (pktType)
          TYPE_OPEN: begin
            if (!locked || originMatch) begin
              strb.doLock   = 1'b1;
              strb.clearAll = 1'b1;
              strb.raiseAck = 1'b1;
              ackValue      = '0;
            end
          end
          TYPE_CLOSE: begin
            if (sameHost) begin
              strb.doRelease = 1'b1;
              strb.clearAll  = 1'b1;
              strb.raiseAck  = 1'b1;
            end
          end
          TYPE_ACK: begin
            if (sameHost) begin
              strb.ackSeen = 1'b1;
              strb.ackHit  = (effNum == txLastNum);
            end
          end
          TYPE_DATA: begin
            if (sameHost && seqHit) begin
              if (lenOk) begin
                strb.commit   = 1'b1;
                strb.raiseAck = 1'b1;
                strb.incSeq   = 1'b1;
              end else begin
                strb.abort = 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
    // A new start while an eligible data packet is open abandons it
    if (inValid && inStart && inPkt && (byteCnt >= IDX_BODY) && fwdOk)
      strb.abort = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
      inPkt   <= 1'b0;
    end else if (accept) begin
      if (inEnd) begin
        byteCnt <= '0;
        inPkt   <= 1'b0;
      end else begin
        byteCnt <= (idx == CNT_TOP) ? idx : idx + 1'b1;
        inPkt   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dgram_rx_datapath.sv
module dgram_rx_datapath
  import dgram_rx_pkg::*;
#(
  parameter int IP_W   = 32,
  parameter int PORT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_strobe_t        strb,
  input  logic [7:0]         inByte,
  input  logic [IP_W-1:0]    srcIp,
  input  logic [PORT_W-1:0]  srcPort,
  input  logic [SEQ_W-1:0]   ackValue,
  output logic [7:0]         pktType,
  output logic [7:0]         numHi,
  output logic [SEQ_W-1:0]   pktNum,
  output logic [SEQ_W-1:0]   expSeq,
  output logic               locked,
  output logic               originMatch,
  output logic               wordValid,
  output logic [WORD_W-1:0]  wordData,
  output logic [LINK_W-1:0]  wordLink,
  output logic               dataCommit,
  output logic               dataAbort,
  output logic               ackReq,
  output logic [SEQ_W-1:0]   ackNum,
  output logic [LINK_W-1:0]  ackLink,
  output logic               ackSeen,
  output logic               ackMatch,
  output logic               clrArp,
  output logic               clrBuf,
  output logic               clrCnt
);

  localparam int SHIFT_W = WORD_W - 8;

  logic [LINK_W-1:0]  linkId;
  logic [IP_W-1:0]    originIp;
  logic [PORT_W-1:0]  originPort;
  logic [IP_W-1:0]    hostIp;
  logic [PORT_W-1:0]  hostPort;
  logic [SHIFT_W-1:0] shiftReg;

  assign originMatch = (originIp == hostIp) && (originPort == hostPort);

  // Header fields and origin of the packet in flight
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkId     <= '0;
      pktType    <= '0;
      numHi      <= '0;
      pktNum     <= '0;
      originIp   <= '0;
      originPort <= '0;
      shiftReg   <= '0;
    end else begin
      if (strb.capLink)   linkId  <= inByte;
      if (strb.capType)   pktType <= inByte;
      if (strb.capNumHi)  numHi   <= inByte;
      if (strb.capNumLo)  pktNum  <= {numHi, inByte};
      if (strb.capOrigin) begin
        originIp   <= srcIp;
        originPort <= srcPort;
      end
      if (strb.pushByte)  shiftReg <= {shiftReg[SHIFT_W-9:0], inByte};
    end
  end

  // Session state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked   <= 1'b0;
      hostIp   <= '0;
      hostPort <= '0;
      expSeq   <= '0;
    end else if (strb.doLock) begin
      locked   <= 1'b1;
      hostIp   <= originIp;
      hostPort <= originPort;
      expSeq   <= '0;
    end else if (strb.doRelease) begin
      locked   <= 1'b0;
      hostIp   <= '0;
      hostPort <= '0;
      expSeq   <= '0;
    end else if (strb.incSeq) begin
      expSeq <= expSeq + 1'b1;
    end
  end

  // Registered block outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid  <= 1'b0;
      wordData   <= '0;
      wordLink   <= '0;
      dataCommit <= 1'b0;
      dataAbort  <= 1'b0;
      ackReq     <= 1'b0;
      ackNum     <= '0;
      ackLink    <= '0;
      ackSeen    <= 1'b0;
      ackMatch   <= 1'b0;
      clrArp     <= 1'b0;
      clrBuf     <= 1'b0;
      clrCnt     <= 1'b0;
    end else begin
      wordValid  <= strb.emitWord;
      dataCommit <= strb.commit;
      dataAbort  <= strb.abort;
      ackReq     <= strb.raiseAck;
      ackSeen    <= strb.ackSeen;
      clrArp     <= strb.clearAll;
      clrBuf     <= strb.clearAll;
      clrCnt     <= strb.clearAll;
      if (strb.emitWord) begin
        wordData <= {shiftReg, inByte};
        wordLink <= linkId;
      end
      if (strb.raiseAck) begin
        ackNum  <= ackValue;
        ackLink <= linkId;
      end
      if (strb.ackSeen) ackMatch <= strb.ackHit;
    end
  end

endmodule

// File: rtl/dgram_rx_engine.sv
module dgram_rx_engine
  import dgram_rx_pkg::*;
#(
  parameter int MAX_WORDS = 360,
  parameter int IP_W      = 32,
  parameter int PORT_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inEnd,
  input  logic [7:0]        inByte,
  input  logic [IP_W-1:0]   srcIp,
  input  logic [PORT_W-1:0] srcPort,
  input  logic [15:0]       txLastNum,
  output logic              wordValid,
  output logic [31:0]       wordData,
  output logic [7:0]        wordLink,
  output logic              dataCommit,
  output logic              dataAbort,
  output logic              ackReq,
  output logic [15:0]       ackNum,
  output logic [7:0]        ackLink,
  output logic              ackSeen,
  output logic              ackMatch,
  output logic              clrArp,
  output logic              clrBuf,
  output logic              clrCnt,
  output logic              sessionLocked
);

  ctl_strobe_t      strb;
  logic [SEQ_W-1:0] ackValue;
  logic [7:0]       pktType;
  logic [7:0]       numHi;
  logic [SEQ_W-1:0] pktNum;
  logic [SEQ_W-1:0] expSeq;
  logic             originMatch;

  dgram_rx_control #(.MAX_WORDS(MAX_WORDS)) u_ctl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inStart(inStart), .inEnd(inEnd), .inByte(inByte),
    .txLastNum(txLastNum),
    .pktType(pktType), .numHi(numHi), .pktNum(pktNum), .expSeq(expSeq),
    .locked(sessionLocked), .originMatch(originMatch),
    .strb(strb), .ackValue(ackValue)
  );

  dgram_rx_datapath #(.IP_W(IP_W), .PORT_W(PORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inByte(inByte),
    .srcIp(srcIp), .srcPort(srcPort), .ackValue(ackValue),
    .pktType(pktType), .numHi(numHi), .pktNum(pktNum), .expSeq(expSeq),
    .locked(sessionLocked), .originMatch(originMatch),
    .wordValid(wordValid), .wordData(wordData), .wordLink(wordLink),
    .dataCommit(dataCommit), .dataAbort(dataAbort),
    .ackReq(ackReq), .ackNum(ackNum), .ackLink(ackLink),
    .ackSeen(ackSeen), .ackMatch(ackMatch),
    .clrArp(clrArp), .clrBuf(clrBuf), .clrCnt(clrCnt)
  );

endmodule

// File: rtl/dgram_rx_checker.sv
module dgram_rx_checker #(
  parameter int MAX_WORDS = 360
) (
  input logic        clk,
  input logic        rstN,
  input logic        wordValid,
  input logic        dataCommit,
  input logic        dataAbort,
  input logic        ackReq,
  input logic [15:0] ackNum,
  input logic        ackSeen,
  input logic        clrArp,
  input logic        clrBuf,
  input logic        clrCnt,
  input logic        sessionLocked
);

  localparam int WC_W = $clog2(MAX_WORDS + 1);
  logic [WC_W-1:0] wordsOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordsOpen <= '0;
    else if (dataCommit || dataAbort) wordsOpen <= '0;
    else if (wordValid) wordsOpen <= wordsOpen + 1'b1;
  end

  assert_word_in_session_R2: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> sessionLocked);

  assert_open_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sessionLocked) |-> (clrArp && clrBuf && ackReq && ackNum == 16'd0));

  assert_commit_acked_R5: assert property (@(posedge clk) disable iff (!rstN)
    dataCommit |-> (ackReq && !dataAbort));

  assert_abort_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataAbort |-> !ackReq);

  assert_word_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (int'(wordsOpen) < MAX_WORDS));

  assert_ack_not_acked_R8: assert property (@(posedge clk) disable iff (!rstN)
    ackSeen |-> (!ackReq && !clrArp));

  assert_close_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sessionLocked) |-> (clrBuf && clrCnt && ackReq));

  assert_clear_acked_R13: assert property (@(posedge clk) disable iff (!rstN)
    clrCnt |-> ackReq);

endmodule

bind dgram_rx_engine dgram_rx_checker #(.MAX_WORDS(MAX_WORDS)) u_chk (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .dataCommit(dataCommit),
  .dataAbort(dataAbort), .ackReq(ackReq), .ackNum(ackNum), .ackSeen(ackSeen),
  .clrArp(clrArp), .clrBuf(clrBuf), .clrCnt(clrCnt), .sessionLocked(sessionLocked)
);

// File: tb/sim_dgram_rx_engine.sv
module sim_dgram_rx_engine;

  localparam int MAXW = 360;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inStart = 1'b0, inEnd = 1'b0;
  logic [7:0]  inByte = '0;
  logic [31:0] srcIp = '0;
  logic [15:0] srcPort = '0;
  logic [15:0] txLastNum = '0;
  logic        wordValid, dataCommit, dataAbort, ackReq, ackSeen, ackMatch;
  logic        clrArp, clrBuf, clrCnt, sessionLocked;
  logic [31:0] wordData;
  logic [7:0]  wordLink, ackLink;
  logic [15:0] ackNum;

  dgram_rx_engine #(.MAX_WORDS(MAXW)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart), .inEnd(inEnd),
    .inByte(inByte), .srcIp(srcIp), .srcPort(srcPort), .txLastNum(txLastNum),
    .wordValid(wordValid), .wordData(wordData), .wordLink(wordLink),
    .dataCommit(dataCommit), .dataAbort(dataAbort), .ackReq(ackReq),
    .ackNum(ackNum), .ackLink(ackLink), .ackSeen(ackSeen), .ackMatch(ackMatch),
    .clrArp(clrArp), .clrBuf(clrBuf), .clrCnt(clrCnt), .sessionLocked(sessionLocked)
  );

  always #10 clk = ~clk;

  int nChecks = 0, nErr = 0;
  int wCnt = 0, aCnt = 0, cmCnt = 0, abCnt = 0, clCnt = 0, sCnt = 0;
  logic [15:0] lastAckNum = '0;
  logic [7:0]  lastAckLink = '0, curLink = '0;
  logic        lastMatch = 1'b0;

  typedef struct packed {
    logic [1:0]  src;
    logic [7:0]  link;
    logic [7:0]  ptype;
    logic [15:0] num;
    logic [15:0] len;
    logic [15:0] txNum;
    logic [15:0] words;
    logic        ack;
    logic [15:0] ackNum;
    logic        commit;
    logic        abort;
    logic        clr;
    logic        seen;
    logic        match;
    logic        locked;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd1, 8'h01, 16'd0,      16'd8,  16'd0, 16'd0, 1'b0, 16'd0,      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd10}, // R10 data unlocked
    '{2'd0, 8'd3, 8'h03, 16'd5,      16'd4,  16'd0, 16'd0, 1'b1, 16'd0,      1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd3},  // R3 open
    '{2'd0, 8'd2, 8'h01, 16'd0,      16'd16, 16'd0, 16'd3, 1'b1, 16'd0,      1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd2},  // R2 R5 three words
    '{2'd0, 8'd2, 8'h01, 16'd1,      16'd4,  16'd0, 16'd0, 1'b1, 16'd1,      1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd5},  // R5 empty payload
    '{2'd0, 8'd2, 8'h01, 16'd1,      16'd8,  16'd0, 16'd0, 1'b0, 16'd0,      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd6},  // R6 duplicate
    '{2'd1, 8'd2, 8'h01, 16'd2,      16'd8,  16'd0, 16'd0, 1'b0, 16'd0,      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 other port
    '{2'd2, 8'd4, 8'h03, 16'd0,      16'd4,  16'd0, 16'd0, 1'b0, 16'd0,      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 other IP open
    '{2'd0, 8'd5, 8'h01, 16'd2,      16'd13, 16'd0, 16'd2, 1'b0, 16'd0,      1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd7},  // R7 ragged length
    '{2'd0, 8'd5, 8'h01, 16'd2,      16'd8,  16'd0, 16'd1, 1'b1, 16'd2,      1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd7},  // R7 seq unchanged
    '{2'd0, 8'd1, 8'h07, 16'd3,      16'd8,  16'd0, 16'd0, 1'b0, 16'd0,      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10}, // R10 unknown type
    '{2'd0, 8'd1, 8'h02, 16'd9,      16'd4,  16'd9, 16'd0, 1'b0, 16'd0,      1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd8},  // R8 match
    '{2'd0, 8'd1, 8'h02, 16'd9,      16'd4,  16'd8, 16'd0, 1'b0, 16'd0,      1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd8},  // R8 mismatch
    '{2'd0, 8'd6, 8'h03, 16'd77,     16'd4,  16'd0, 16'd0, 1'b1, 16'd0,      1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd13}, // R13 reopen
    '{2'd0, 8'd6, 8'h01, 16'd0,      16'd8,  16'd0, 16'd1, 1'b1, 16'd0,      1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd13}, // R13 seq back to 0
    '{2'd0, 8'd6, 8'h04, 16'h1234,   16'd4,  16'd0, 16'd0, 1'b1, 16'h1234,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd9},  // R9 close
    '{2'd0, 8'd6, 8'h01, 16'd1,      16'd8,  16'd0, 16'd0, 1'b0, 16'd0,      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9},  // R9 after close
    '{2'd1, 8'd7, 8'h03, 16'd0,      16'd3,  16'd0, 16'd0, 1'b0, 16'd0,      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11}, // R11 runt
    '{2'd1, 8'd7, 8'h03, 16'd0,      16'd4,  16'd0, 16'd0, 1'b1, 16'd0,      1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd3}   // R3 open by B
  };

  function automatic logic [7:0] pat(input logic [7:0] link, input int p);
    int t;
    t = int'(link) * 13 + p * 7 + 5;
    return t[7:0];
  endfunction

  function automatic logic [7:0] byteAt(input logic [7:0] link, input logic [7:0] ptype,
                                        input logic [15:0] num, input int j);
    if (j == 0) return link;
    if (j == 1) return ptype;
    if (j == 2) return num[15:8];
    if (j == 3) return num[7:0];
    return pat(link, j - 4);
  endfunction

  function automatic logic [31:0] expWord(input logic [7:0] link, input int k);
    return {pat(link, 4*k), pat(link, 4*k+1), pat(link, 4*k+2), pat(link, 4*k+3)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Output monitor, samples away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (wordValid) begin
        chk(wordData == expWord(curLink, wCnt), "R2", "word data", wordData, expWord(curLink, wCnt));
        chk(wordLink == curLink, "R2", "word link", wordLink, curLink);
        wCnt++;
      end
      if (ackReq) begin aCnt++; lastAckNum = ackNum; lastAckLink = ackLink; end
      if (dataCommit) cmCnt++;
      if (dataAbort) abCnt++;
      if (clrArp || clrBuf || clrCnt) begin
        clCnt++;
        chk(clrArp && clrBuf && clrCnt, "R3", "clear strobes together",
            {clrArp, clrBuf, clrCnt}, 3'b111);
      end
      if (ackSeen) begin sCnt++; lastMatch = ackMatch; end
    end
  end

  task automatic clearMon(input logic [7:0] link);
    @(posedge clk); #2;
    wCnt = 0; aCnt = 0; cmCnt = 0; abCnt = 0; clCnt = 0; sCnt = 0;
    curLink = link;
  endtask

  task automatic setSrc(input logic [1:0] src);
    srcIp   = (src == 2'd2) ? 32'hC0A8_0042 : 32'hC0A8_0085;
    srcPort = (src == 2'd1) ? 16'd1235 : 16'd1234;
  endtask

  task automatic sendPkt(input logic [1:0] src, input logic [7:0] link,
                         input logic [7:0] ptype, input logic [15:0] num, input int len);
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      setSrc(src);
      inValid = 1'b1;
      inStart = (j == 0);
      inEnd   = (j == len - 1);
      inByte  = byteAt(link, ptype, num, j);
    end
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    string rq;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!sessionLocked, "R1", "locked after reset", sessionLocked, 0);
    chk(!wordValid && !ackReq && !ackSeen, "R1", "pulses after reset",
        {wordValid, ackReq, ackSeen}, 0);
    chk(!clrArp && !clrBuf && !clrCnt && !dataCommit && !dataAbort, "R1",
        "clears after reset", {clrArp, clrBuf, clrCnt, dataCommit, dataAbort}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      rq = $sformatf("R%0d", v.req);
      txLastNum = v.txNum;
      clearMon(v.link);
      sendPkt(v.src, v.link, v.ptype, v.num, int'(v.len));
      @(posedge clk); #2;
      chk(wCnt == int'(v.words), rq, $sformatf("vec %0d words", i), wCnt, v.words);
      chk(aCnt == int'(v.ack), rq, $sformatf("vec %0d ack requests", i), aCnt, v.ack);
      if (v.ack) begin
        chk(lastAckNum == v.ackNum, rq, $sformatf("vec %0d ack number", i), lastAckNum, v.ackNum);
        chk(lastAckLink == v.link, rq, $sformatf("vec %0d ack link", i), lastAckLink, v.link);
      end
      chk(cmCnt == int'(v.commit), rq, $sformatf("vec %0d commit", i), cmCnt, v.commit);
      chk(abCnt == int'(v.abort), rq, $sformatf("vec %0d abort", i), abCnt, v.abort);
      chk(clCnt == int'(v.clr), rq, $sformatf("vec %0d clears", i), clCnt, v.clr);
      chk(sCnt == int'(v.seen), rq, $sformatf("vec %0d ack seen", i), sCnt, v.seen);
      if (v.seen)
        chk(lastMatch == v.match, rq, $sformatf("vec %0d ack match", i), lastMatch, v.match);
      chk(sessionLocked == v.locked, rq, $sformatf("vec %0d locked", i), sessionLocked, v.locked);
    end

    // R7 oversize: one word beyond the cap, session held by B, expected 0
    clearMon(8'd7);
    sendPkt(2'd1, 8'd7, 8'h01, 16'd0, 4 + 4 * (MAXW + 1));
    @(posedge clk); #2;
    chk(wCnt == MAXW, "R7", "oversize words", wCnt, MAXW);
    chk(abCnt == 1 && cmCnt == 0, "R7", "oversize abort", abCnt, 1);
    chk(aCnt == 0, "R7", "oversize ack", aCnt, 0);

    // R12 timing: one-word data packet driven byte by byte, number 0 still expected
    clearMon(8'd7);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      setSrc(2'd1);
      inValid = 1'b1; inStart = (j == 0); inEnd = (j == 7);
      inByte = byteAt(8'd7, 8'h01, 16'd0, j);
      if (j == 7) chk(!wordValid && !ackReq, "R12", "outputs before last edge",
                      {wordValid, ackReq}, 0);
    end
    @(posedge clk); #2;
    chk(wordValid && ackReq && dataCommit, "R12", "word and ack one cycle after last byte",
        {wordValid, ackReq, dataCommit}, 3'b111);
    chk(ackNum == 16'd0, "R12", "ack number", ackNum, 0);
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
    @(posedge clk); #2;
    chk(!wordValid && !ackReq && !dataCommit, "R12", "single-cycle pulses",
        {wordValid, ackReq, dataCommit}, 0);

    // R1 reset during a session forgets the host
    chk(sessionLocked, "R1", "locked before reset", sessionLocked, 1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk(!sessionLocked, "R1", "locked during reset", sessionLocked, 0);
    rstN = 1'b1;
    clearMon(8'd7);
    sendPkt(2'd1, 8'd7, 8'h01, 16'd1, 8);
    @(posedge clk); #2;
    chk(wCnt == 0 && aCnt == 0, "R1", "data dropped after reset", wCnt + aCnt, 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule